// File: doc/BRIEF.md
# Sinc-cubed decimation filter

This block turns a one-bit oversampled bitstream into signed sixteen-bit sample words. Every pulse on the bit strobe carries one modulator bit. A bit of 1 counts as +1 and a bit of 0 counts as −1. Three integrators accumulate these values at the strobe rate. After every R strobes, three comb (difference) stages run once and produce one filtered value. The ratio R is selected at run time and can be 32, 64, 128 or 256.

The filtered value has a DC gain of R³. It is cut down to a fifteen-bit two's-complement number by dropping low-order bits, so full scale lands on ±2¹⁴ whatever the ratio. That number is then shifted up one place to make a sixteen-bit word. A positive full-scale result is clamped to 0x7FFF. A channel can have its result negated: this needs both a per-channel select and a global enable.

When the ratio changes, the filter clears its state. It then drops the first three decimated results, because these still mix in the cleared history.

Top module: `sinc3_decim`

## Requirements
- R1: Reset is synchronous and active high. While it is asserted and afterwards, `word` reads 0x0000 and `word_vld` is low. Strobes seen during reset have no effect.
- R2: The ratio is R = 32·2^`rate_sel` (00→32, 01→64, 10→128, 11→256). After reset or after a ratio change, the first `word_vld` follows exactly 4R strobes, and later pulses follow every R strobes. Each pulse lasts one cycle and comes three clock edges after the strobe that completes a block.
- R3: The bit 1 counts as +1 and the bit 0 counts as −1. The fifteen-bit result is the sinc3 sum arithmetically shifted right by 3·log2(R)−14. The word is that result shifted left one place with bit 0 cleared. Repeating patterns give fixed words at every ratio: 1110 gives 0x4000, 1000 gives 0xC000, 1010 gives 0x0000, and all zeros gives 0x8000.
- R4: A result at or above positive full scale (for example an all-ones stream) gives 0x7FFF. This is the only word with bit 0 set.
- R5: When `inv_sel` and `inv_en` are both high, the sum is negated before truncation and clamping. With inversion, 1110 gives 0xC000, all ones gives 0x8000, and all zeros gives 0x7FFF.
- R6: With only one of `inv_sel` or `inv_en` high, the word is the same as with no inversion.
- R7: A change of `rate_sel` clears the whole filter. No `word_vld` appears in the cycle after the change. The first word after the change depends only on bits received after it.
- R8: `word` changes only at a `word_vld` pulse, and holds its value between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Modulator bit, sampled when `bit_stb` is high |
| bit_stb | input | 1 | One-cycle strobe marking a new modulator bit |
| rate_sel | input | 2 | Decimation ratio select, R = 32·2^rate_sel |
| inv_sel | input | 1 | Per-channel invert select |
| inv_en | input | 1 | Global invert enable |
| word | output | 16 | Two's-complement sample word |
| word_vld | output | 1 | One-cycle pulse when `word` is updated |

## Verification
The bench builds the filter with its default parameters: a minimum ratio of 32, a two-bit rate select, a third-order filter and a fifteen-bit result. With these values all four ratios can be reached, including 256, where the 26-bit accumulators carry the full 2²⁴ gain and must wrap correctly. Periodic bit patterns whose period divides every ratio give exact expected words, because the sinc3 nulls remove everything except the mean. The pulse count after a reset or a ratio change can then be checked to the strobe: 256 strobes at ratio 64, and 512 strobes at ratio 128.

// File: rtl/sinc3_pkg.sv
`timescale 1ns/1ps
package sinc3_pkg;

  // log2 of the decimation ratio for a given select code
  function automatic int ratio_log2(input int log2_rmin, input int sel);
    return log2_rmin + sel;
  endfunction

  // right shift that maps a gain of R^order onto a q_w-bit signed range
  function automatic int trunc_shift(input int order, input int log2_r, input int q_w);
    return order * log2_r - (q_w - 1);
  endfunction

endpackage

// File: rtl/sinc3_integ.sv
`timescale 1ns/1ps
module sinc3_integ #(
  parameter int ORDER = 3,
  parameter int ACC_W = 26
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             stb,
  input  logic             bit_in,
  output logic [ACC_W-1:0] acc_out
);

  logic [ORDER-1:0][ACC_W-1:0] acc;
  logic [ACC_W-1:0]            x_val;

  // +1 for a one, -1 (all ones) for a zero
  assign x_val = bit_in ? ACC_W'(1) : {ACC_W{1'b1}};

  // integrators wrap modulo 2^ACC_W; the comb differences stay exact
  always_ff @(posedge clk) begin
    if (clr) begin
      acc <= '0;
    end else if (stb) begin
      acc[0] <= acc[0] + x_val;
      for (int k = 1; k < ORDER; k++) begin
        acc[k] <= acc[k] + acc[k-1];
      end
    end
  end

  assign acc_out = acc[ORDER-1];

endmodule

// File: rtl/sinc3_comb.sv
`timescale 1ns/1ps
module sinc3_comb #(
  parameter int ORDER = 3,
  parameter int ACC_W = 26
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             tick,
  input  logic [ACC_W-1:0] din,
  output logic [ACC_W-1:0] dout,
  output logic             dvld
);

  for (genvar g = 0; g < ORDER; g++) begin : g_stage
    logic [ACC_W-1:0] src;
    logic [ACC_W-1:0] dly_q;
    logic [ACC_W-1:0] diff;

    if (g == 0) begin : g_head
      assign src = din;
    end else begin : g_tail
      assign src = g_stage[g-1].diff;
    end

    assign diff = src - dly_q;

    always_ff @(posedge clk) begin
      if (clr)       dly_q <= '0;
      else if (tick) dly_q <= src;
    end
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      dout <= '0;
      dvld <= 1'b0;
    end else begin
      dvld <= tick;
      if (tick) dout <= g_stage[ORDER-1].diff;
    end
  end

endmodule

// File: rtl/sinc3_fmt.sv
`timescale 1ns/1ps
module sinc3_fmt
  import sinc3_pkg::*;
#(
  parameter int ORDER     = 3,
  parameter int ACC_W     = 26,
  parameter int Q_W       = 15,
  parameter int LOG2_RMIN = 5,
  parameter int RATE_W    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              tick,
  input  logic              allow,
  input  logic              inv,
  input  logic [RATE_W-1:0] rate,
  input  logic [ACC_W-1:0]  y,
  output logic [Q_W:0]      word,
  output logic              vld
);

  localparam logic signed [ACC_W-1:0] Q_MAX = ACC_W'((1 << (Q_W - 1)) - 1);
  localparam logic [Q_W:0]            W_SAT = {1'b0, {Q_W{1'b1}}};

  int                      sh;
  logic signed [ACC_W-1:0] v_s;
  logic signed [ACC_W-1:0] q_s;
  logic [Q_W:0]            w_nxt;

  always_comb begin
    sh    = trunc_shift(ORDER, ratio_log2(LOG2_RMIN, int'(rate)), Q_W);
    v_s   = inv ? $signed(-y) : $signed(y);
    q_s   = v_s >>> sh;
    if (q_s > Q_MAX) w_nxt = W_SAT;
    else             w_nxt = {q_s[Q_W-1:0], 1'b0};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word <= '0;
      vld  <= 1'b0;
    end else begin
      vld <= 1'b0;
      if (!flush && tick && allow) begin
        vld  <= 1'b1;
        word <= w_nxt;
      end
    end
  end

endmodule

// File: rtl/sinc3_decim.sv
`timescale 1ns/1ps
module sinc3_decim #(
  parameter int LOG2_RMIN = 5,
  parameter int RATE_W    = 2,
  parameter int Q_W       = 15,
  parameter int ORDER     = 3,
  parameter int SKIP_N    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_in,
  input  logic              bit_stb,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              inv_sel,
  input  logic              inv_en,
  output logic [Q_W:0]      word,
  output logic              word_vld
);

  localparam int LOG2_RMAX = LOG2_RMIN + (1 << RATE_W) - 1;
  localparam int ACC_W     = ORDER * LOG2_RMAX + 2;
  localparam int CNT_W     = LOG2_RMAX;
  localparam int SKIP_W    = $clog2(SKIP_N + 1);

  logic [RATE_W-1:0] rate_q;
  logic              flush;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  cnt_top;
  logic              dec;
  logic [SKIP_W-1:0] skip;
  logic [ACC_W-1:0]  integ_out;
  logic [ACC_W-1:0]  comb_out;
  logic              comb_vld;

  assign flush   = rst || (rate_sel != rate_q);
  assign cnt_top = CNT_W'((1 << (LOG2_RMIN + int'(rate_q))) - 1);

  // strobe phase counter, decimation tick and ratio capture
  always_ff @(posedge clk) begin
    if (flush) begin
      rate_q <= rate_sel;
      cnt    <= '0;
      dec    <= 1'b0;
    end else begin
      dec <= bit_stb && (cnt == cnt_top);
      if (bit_stb) cnt <= (cnt == cnt_top) ? '0 : cnt + 1'b1;
    end
  end

  // drop the first SKIP_N comb results after a flush
  always_ff @(posedge clk) begin
    if (flush)                        skip <= SKIP_W'(SKIP_N);
    else if (comb_vld && skip != '0) skip <= skip - 1'b1;
  end

  sinc3_integ #(.ORDER(ORDER), .ACC_W(ACC_W)) u_integ (
    .clk(clk), .clr(flush), .stb(bit_stb), .bit_in(bit_in), .acc_out(integ_out)
  );

  sinc3_comb #(.ORDER(ORDER), .ACC_W(ACC_W)) u_comb (
    .clk(clk), .clr(flush), .tick(dec), .din(integ_out),
    .dout(comb_out), .dvld(comb_vld)
  );

  sinc3_fmt #(
    .ORDER(ORDER), .ACC_W(ACC_W), .Q_W(Q_W),
    .LOG2_RMIN(LOG2_RMIN), .RATE_W(RATE_W)
  ) u_fmt (
    .clk(clk), .rst(rst), .flush(flush), .tick(comb_vld),
    .allow(skip == '0), .inv(inv_sel && inv_en), .rate(rate_q),
    .y(comb_out), .word(word), .vld(word_vld)
  );

endmodule

// File: rtl/sinc3_decim_chk.sv
`timescale 1ns/1ps
module sinc3_decim_chk #(
  parameter int W      = 16,
  parameter int RATE_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              bit_stb,
  input logic [RATE_W-1:0] rate_sel,
  input logic [W-1:0]      word,
  input logic              word_vld
);

  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  // R1: outputs are quiet on the edge after a reset cycle
  always @(posedge clk) begin
    if (rst_d) begin
      p_rst_quiet_r1: assert (!word_vld && word == '0);
    end
  end

  // R2: a valid pulse is preceded by a strobe three edges earlier
  p_after_stb_r2: assert property (@(posedge clk) disable iff (rst)
    word_vld |-> $past(bit_stb, 3));

  // R2: valid lasts exactly one cycle
  p_one_cycle_r2: assert property (@(posedge clk) disable iff (rst)
    word_vld |=> !word_vld);

  // R4: the only word with a set LSB is positive saturation
  p_sat_lsb_r4: assert property (@(posedge clk) disable iff (rst)
    (word_vld && word[0]) |-> (word == {1'b0, {(W-1){1'b1}}}));

  // R7: a ratio change kills any pending result
  p_flush_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(rate_sel) |=> !word_vld);

  // R8: word holds between pulses
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!word_vld && !$past(rst)) |-> $stable(word));

endmodule

bind sinc3_decim sinc3_decim_chk #(.W(Q_W + 1), .RATE_W(RATE_W)) u_chk (
  .clk(clk), .rst(rst), .bit_stb(bit_stb), .rate_sel(rate_sel),
  .word(word), .word_vld(word_vld)
);

// File: tb/sim_sinc3_decim.sv
`timescale 1ns/1ps
module sim_sinc3_decim;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bit_in = 1'b0;
  logic        bit_stb = 1'b0;
  logic [1:0]  rate_sel = 2'd0;
  logic        inv_sel = 1'b0;
  logic        inv_en = 1'b0;
  logic [15:0] word;
  logic        word_vld;

  always #2 clk = ~clk;

  sinc3_decim u0 (
    .clk(clk), .rst(rst), .bit_in(bit_in), .bit_stb(bit_stb),
    .rate_sel(rate_sel), .inv_sel(inv_sel), .inv_en(inv_en),
    .word(word), .word_vld(word_vld)
  );

  int          n_chk = 0;
  int          n_fail = 0;
  int          nv = 0;
  int          ph = 0;
  logic [15:0] firstw = '0;
  logic [15:0] lastw = '0;
  bit          done = 1'b0;

  always @(negedge clk) begin
    if (word_vld) begin
      if (nv == 0) firstw = word;
      nv++;
      lastw = word;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] r);
    @(negedge clk);
    rst = 1'b1; rate_sel = r; bit_stb = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    nv = 0; ph = 0;
  endtask

  // one strobe every five cycles; outputs are settled before the next
  task automatic send(input int n, input logic [3:0] pat);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bit_in = pat[3-ph]; bit_stb = 1'b1; ph = (ph + 1) % 4;
      @(negedge clk);
      bit_stb = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic t_value(input logic [1:0] r, input logic [3:0] pat,
                         input logic is, input logic ie,
                         input logic [15:0] exp, input string req);
    int rr;
    rr = 32 << r;
    inv_sel = is; inv_en = ie;
    do_reset(r);
    send(6 * rr, pat);
    chk({req, " pulse count"}, nv, 3);
    chk({req, " first word"}, firstw, exp);
    chk({req, " last word"}, lastw, exp);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    send(4, 4'b1111);
    chk("R1 vld in reset", word_vld, 0);
    chk("R1 word in reset", word, 0);
    chk("R1 no pulse in reset", nv, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 word after reset", word, 0);
    chk("R1 vld after reset", word_vld, 0);
  endtask

  task automatic t_latency();
    int cnt;
    inv_sel = 0; inv_en = 0;
    do_reset(2'd1);
    cnt = 0;
    while (nv == 0 && cnt < 2000) begin send(1, 4'b1110); cnt++; end
    chk("R2 strobes to first pulse at R=64", cnt, 256);
    chk("R3 first word after reset", firstw, 16'h4000);
    cnt = 0;
    while (nv == 1 && cnt < 2000) begin send(1, 4'b1110); cnt++; end
    chk("R2 strobes between pulses at R=64", cnt, 64);
    chk("R8 second word", lastw, 16'h4000);
  endtask

  task automatic t_rate_change();
    int cnt;
    inv_sel = 0; inv_en = 0;
    do_reset(2'd0);
    send(160, 4'b1110);
    chk("R2 pulses before change", nv, 2);
    chk("R3 word before change", lastw, 16'h4000);
    @(negedge clk);
    rate_sel = 2'd2;
    repeat (3) @(negedge clk);
    chk("R8 word held across change", word, 16'h4000);
    nv = 0; ph = 0;
    cnt = 0;
    while (nv == 0 && cnt < 3000) begin send(1, 4'b1000); cnt++; end
    chk("R7 strobes to first pulse after change", cnt, 512);
    chk("R7 first word uses new data only", firstw, 16'h0C000);
  endtask

  initial begin
    #(150000 * 4);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset();
    // R3 mean-to-word mapping at several ratios
    t_value(2'd0, 4'b1110, 0, 0, 16'h4000, "R3 1110 R=32");
    t_value(2'd0, 4'b1000, 0, 0, 16'hC000, "R3 1000 R=32");
    t_value(2'd0, 4'b1010, 0, 0, 16'h0000, "R3 1010 R=32");
    t_value(2'd0, 4'b0000, 0, 0, 16'h8000, "R3 zeros R=32");
    t_value(2'd3, 4'b1110, 0, 0, 16'h4000, "R3 1110 R=256");
    t_value(2'd1, 4'b1000, 0, 0, 16'hC000, "R3 1000 R=64");
    t_value(2'd2, 4'b1010, 0, 0, 16'h0000, "R3 1010 R=128");
    // R4 saturation at every ratio
    t_value(2'd0, 4'b1111, 0, 0, 16'h7FFF, "R4 ones R=32");
    t_value(2'd1, 4'b1111, 0, 0, 16'h7FFF, "R4 ones R=64");
    t_value(2'd2, 4'b1111, 0, 0, 16'h7FFF, "R4 ones R=128");
    t_value(2'd3, 4'b1111, 0, 0, 16'h7FFF, "R4 ones R=256");
    // R5 inversion
    t_value(2'd0, 4'b1110, 1, 1, 16'hC000, "R5 inv 1110");
    t_value(2'd0, 4'b1111, 1, 1, 16'h8000, "R5 inv ones");
    t_value(2'd1, 4'b0000, 1, 1, 16'h7FFF, "R5 inv zeros sat");
    // R6 one control alone does nothing
    t_value(2'd0, 4'b1110, 1, 0, 16'h4000, "R6 select only");
    t_value(2'd0, 4'b1110, 0, 1, 16'h4000, "R6 enable only");
    t_latency();
    t_rate_change();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule